// File: doc/BRIEF.md
# Three-Level Carrier-Comparison Gate Modulator

This block turns three signed phase references into gate commands for a three-phase, three-level bridge whose midpoint is clamped by diodes. Each phase leg has four switches. A free-running up/down counter forms a triangle. The upper carrier is this triangle, spanning 0 to +full scale. The lower carrier is its negation, spanning -full scale to 0, so the two carriers share frequency and amplitude and run in opposite phase. Every phase reference is first shifted by one common zero-sequence offset, which is limited to a small band. The shifted value is then compared against both carriers. One comparison drives the outer-upper / inner-lower switch pair and the other drives the inner-upper / outer-lower pair, which gives the positive, neutral and negative output levels.

References arrive as a valid/ready stream. Each beat carries the three phase words and the offset. One beat can wait in a staging register. It is applied only when the upper carrier reaches its maximum, so the switch pattern stays fixed for the rest of that carrier period. While a beat waits, `in_ready` stays low. The sender must then hold the beat steady with `in_valid` high until `in_ready` returns, which happens in the cycle after the next carrier peak. Each complementary switch pair gets a programmable blanking time, in clock cycles, during which both of its switches are off. For each phase the block also outputs a code for the commanded level.

With the default parameters and a 200 MHz clock, the carrier runs at about 9.6 kHz.

Top module: `pwm3l_modulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all twelve gate outputs are 0, all level codes are 00 and `in_ready` is 1.
- R2: A beat is taken on a rising edge where `in_valid` and `in_ready` are both 1. After that `in_ready` is 0 until the edge at which the counter sits at `CAR_TOP`. At that edge the staged beat becomes the active reference and `in_ready` returns to 1.
- R3: The offset is limited to ±floor(`CAR_TOP`·`OFS_PERMIL`/1000) before it is added. The same limited value is added to all three phases.
- R4: The sum of a phase word and the limited offset saturates at ±`CAR_TOP` and never wraps.
- R5: The counter steps by one each cycle from 0 up to `CAR_TOP` and back, so the carrier period is 2·`CAR_TOP` cycles. The upper carrier equals the counter and the lower carrier equals its negation.
- R6: Gate bits are, per phase: bit0 outer-upper, bit1 inner-upper, bit2 inner-lower, bit3 outer-lower. The bit0 command is on exactly when the active word is strictly greater than the upper carrier, and the bit2 command is its complement.
- R7: The bit3 command is on exactly when the active word is strictly less than the lower carrier, and the bit1 command is its complement.
- R8: The level code is 01 when bit0 is commanded (positive), 11 when bit3 is commanded (negative) and 00 otherwise (neutral). Level codes and gates change two cycles after the counter value that caused them.
- R9: A gate turns on `dead_cyc` cycles later than its command, and it turns off without that extra delay. The two switches of a complementary pair are never on together, and each switch-over leaves both of them off for exactly `dead_cyc` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Reference beat valid |
| in_ready | output | 1 | Staging register free |
| in_ph_a | input | DW | Phase A reference, signed |
| in_ph_b | input | DW | Phase B reference, signed |
| in_ph_c | input | DW | Phase C reference, signed |
| in_zero_seq | input | DW | Common zero-sequence offset, signed |
| dead_cyc | input | DT_W | Blanking time in clock cycles |
| gate_a | output | 4 | Phase A switch commands |
| gate_b | output | 4 | Phase B switch commands |
| gate_c | output | 4 | Phase C switch commands |
| level_a | output | 2 | Phase A level code |
| level_b | output | 2 | Phase B level code |
| level_c | output | 2 | Phase C level code |

## Verification
The assertions check a fixed set of rules on every cycle. The two switches of each complementary pair are never on together. Every level code is legal and agrees with which gates are off. `in_ready` stays low from acceptance until a carrier peak. The carrier never stays at its peak for two cycles. Only the bench's scenarios can show the timing-dependent behaviour: the exact duty per carrier period for given words, offset limiting, saturation without wrap, the carrier period, and a blanking time of exactly `dead_cyc` cycles. These are checked against a behavioural cycle model.

// File: rtl/pwm3l_pkg.sv
package pwm3l_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_e;
endpackage

// File: rtl/pwm3l_carrier.sv
module pwm3l_carrier #(
  parameter int TOP = 10416,
  localparam int CW = $clog2(TOP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] ramp,
  output logic          peak
);
  logic rising;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp   <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      ramp <= ramp + 1'b1;
      if (ramp == CW'(TOP - 1)) rising <= 1'b0;
    end else begin
      ramp <= ramp - 1'b1;
      if (ramp == CW'(1)) rising <= 1'b1;
    end
  end

  assign peak = (ramp == CW'(TOP));
endmodule

// File: rtl/pwm3l_stage.sv
module pwm3l_stage #(
  parameter int DW         = 16,
  parameter int TOP        = 10416,
  parameter int OFS_PERMIL = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0][DW-1:0]  in_w,
  input  logic [DW-1:0]       in_ofs,
  input  logic                peak,
  output logic [2:0][DW-1:0]  act_w
);
  localparam int OMAX_I = TOP * OFS_PERMIL / 1000;
  localparam logic signed [DW:0] FS_P = (DW + 1)'(TOP);
  localparam logic signed [DW:0] OM_P = (DW + 1)'(OMAX_I);

  logic                full;
  logic [2:0][DW-1:0]  stg_w;
  logic [DW-1:0]       stg_ofs;
  logic signed [DW:0]  ofs_c;
  logic [2:0][DW-1:0]  sat_w;

  function automatic logic signed [DW:0] lim(input logic signed [DW:0] v,
                                             input logic signed [DW:0] hi);
    if (v > hi) return hi;
    else if (v < -hi) return -hi;
    else return v;
  endfunction

  function automatic logic [DW-1:0] narrow(input logic signed [DW:0] v);
    logic signed [DW:0] t;
    t = lim(v, FS_P);
    return t[DW-1:0];
  endfunction

  assign ofs_c = lim($signed({stg_ofs[DW-1], stg_ofs}), OM_P);

  for (genvar p = 0; p < 3; p++) begin : g_sum
    logic signed [DW:0] sum;
    assign sum      = $signed({stg_w[p][DW-1], stg_w[p]}) + ofs_c;
    assign sat_w[p] = narrow(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      stg_w   <= '0;
      stg_ofs <= '0;
      act_w   <= '0;
    end else if (in_valid && !full) begin
      stg_w   <= in_w;
      stg_ofs <= in_ofs;
      full    <= 1'b1;
    end else if (peak && full) begin
      act_w <= sat_w;
      full  <= 1'b0;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/pwm3l_deadband.sv
module pwm3l_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead,
  output logic            gate
);
  logic [DT_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      gate <= 1'b0;
    end else if (!cmd) begin
      held <= '0;
      gate <= 1'b0;
    end else if (held >= dead) begin
      gate <= 1'b1;
    end else begin
      held <= held + 1'b1;
    end
  end
endmodule

// File: rtl/pwm3l_phase.sv
module pwm3l_phase #(
  parameter int DW   = 16,
  parameter int CW   = 14,
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   ramp,
  input  logic [DW-1:0]   w,
  input  logic [DT_W-1:0] dead,
  output logic [3:0]      gate,
  output logic [1:0]      level
);
  import pwm3l_pkg::*;

  logic signed [DW:0] c_hi, c_lo, wx;
  logic               above, below;
  logic [3:0]         cmd;
  lvl_e               lvl_q;

  assign c_hi  = $signed((DW + 1)'(ramp));
  assign c_lo  = -c_hi;
  assign wx    = $signed({w[DW-1], w});
  assign above = (wx > c_hi);
  assign below = (wx < c_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      lvl_q <= LVL_ZERO;
    end else begin
      cmd <= {below, ~above, ~below, above};
      if (cmd[0])      lvl_q <= LVL_POS;
      else if (cmd[3]) lvl_q <= LVL_NEG;
      else             lvl_q <= LVL_ZERO;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_sw
    pwm3l_deadband #(.DT_W(DT_W)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .cmd  (cmd[k]),
      .dead (dead),
      .gate (gate[k])
    );
  end

  assign level = lvl_q;
endmodule

// File: rtl/pwm3l_modulator.sv
module pwm3l_modulator #(
  parameter int DW         = 16,
  parameter int CAR_TOP    = 10416,
  parameter int OFS_PERMIL = 50,
  parameter int DT_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_ph_a,
  input  logic [DW-1:0]   in_ph_b,
  input  logic [DW-1:0]   in_ph_c,
  input  logic [DW-1:0]   in_zero_seq,
  input  logic [DT_W-1:0] dead_cyc,
  output logic [3:0]      gate_a,
  output logic [3:0]      gate_b,
  output logic [3:0]      gate_c,
  output logic [1:0]      level_a,
  output logic [1:0]      level_b,
  output logic [1:0]      level_c
);
  localparam int CW = $clog2(CAR_TOP + 1);

  logic [CW-1:0]      ramp;
  logic               car_peak;
  logic [2:0][DW-1:0] act_w;
  logic [2:0][3:0]    gates;
  logic [2:0][1:0]    lvls;

  pwm3l_carrier #(.TOP(CAR_TOP)) u_car (
    .clk  (clk),
    .rst_n(rst_n),
    .ramp (ramp),
    .peak (car_peak)
  );

  pwm3l_stage #(.DW(DW), .TOP(CAR_TOP), .OFS_PERMIL(OFS_PERMIL)) u_stg (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_w    ({in_ph_c, in_ph_b, in_ph_a}),
    .in_ofs  (in_zero_seq),
    .peak    (car_peak),
    .act_w   (act_w)
  );

  for (genvar p = 0; p < 3; p++) begin : g_leg
    pwm3l_phase #(.DW(DW), .CW(CW), .DT_W(DT_W)) u_ph (
      .clk  (clk),
      .rst_n(rst_n),
      .ramp (ramp),
      .w    (act_w[p]),
      .dead (dead_cyc),
      .gate (gates[p]),
      .level(lvls[p])
    );
  end

  assign gate_a  = gates[0];
  assign gate_b  = gates[1];
  assign gate_c  = gates[2];
  assign level_a = lvls[0];
  assign level_b = lvls[1];
  assign level_c = lvls[2];
endmodule

// File: rtl/pwm3l_checker.sv
module pwm3l_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       car_peak,
  input logic [3:0] gate_a,
  input logic [3:0] gate_b,
  input logic [3:0] gate_c,
  input logic [1:0] level_a,
  input logic [1:0] level_b,
  input logic [1:0] level_c
);
  logic [2:0][3:0] g;
  logic [2:0][1:0] lv;
  assign g  = {gate_c, gate_b, gate_a};
  assign lv = {level_c, level_b, level_a};

  a_r2_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_hold_until_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !car_peak) |=> !in_ready);

  a_r5_peak_single: assert property (@(posedge clk) disable iff (!rst_n)
    car_peak |=> !car_peak);

  for (genvar i = 0; i < 3; i++) begin : g_ph
    a_r9_outer_up_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(g[i][0] && g[i][2]));
    a_r9_inner_up_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(g[i][1] && g[i][3]));
    a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      lv[i] != 2'b10);
    a_r8_pos_lower_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lv[i] == 2'b01) |-> (!g[i][2] && !g[i][3]));
    a_r8_neg_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lv[i] == 2'b11) |-> (!g[i][0] && !g[i][1]));
    a_r8_zero_outer_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lv[i] == 2'b00) |-> (!g[i][0] && !g[i][3]));
  end
endmodule

bind pwm3l_modulator pwm3l_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .car_peak(car_peak),
  .gate_a  (gate_a),
  .gate_b  (gate_b),
  .gate_c  (gate_c),
  .level_a (level_a),
  .level_b (level_b),
  .level_c (level_c)
);

// File: tb/test_pwm3l_modulator.sv
`timescale 1ns/1ps
module test_pwm3l_modulator;
  localparam int DW = 16, TOP = 100, PERMIL = 50, DTW = 6;
  localparam int OMAX = TOP * PERMIL / 1000;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] pa = '0, pb = '0, pc = '0, pz = '0;
  logic [DTW-1:0] dead = '0;
  logic in_ready;
  logic [3:0] gate_a, gate_b, gate_c;
  logic [1:0] level_a, level_b, level_c;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit running = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  pwm3l_modulator #(.DW(DW), .CAR_TOP(TOP), .OFS_PERMIL(PERMIL), .DT_W(DTW)) i_pwm3l_modulator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ph_a(pa), .in_ph_b(pb), .in_ph_c(pc), .in_zero_seq(pz), .dead_cyc(dead),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
    .level_a(level_a), .level_b(level_b), .level_c(level_c));

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ramp = 0, m_up = 1, m_full = 0, m_sofs = 0;
  int m_stg[3], m_act[3], m_lv[3];
  bit m_id[3][4], m_g[3][4];
  int m_cnt[3][4];

  function automatic int clampi(int v, int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int packg(int p);
    return m_g[p][0] + 2 * m_g[p][1] + 4 * m_g[p][2] + 8 * m_g[p][3];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ramp = 0; m_up = 1; m_full = 0; m_sofs = 0;
      for (int p = 0; p < 3; p++) begin
        m_stg[p] = 0; m_act[p] = 0; m_lv[p] = 0;
        for (int k = 0; k < 4; k++) begin
          m_id[p][k] = 0; m_g[p][k] = 0; m_cnt[p][k] = 0;
        end
      end
    end else begin
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k < 4; k++) begin
          if (!m_id[p][k]) begin m_cnt[p][k] = 0; m_g[p][k] = 0; end
          else if (m_cnt[p][k] >= int'(dead)) m_g[p][k] = 1;
          else m_cnt[p][k]++;
        end
        m_lv[p] = m_id[p][0] ? 1 : (m_id[p][3] ? 3 : 0);
      end
      for (int p = 0; p < 3; p++) begin
        bit hi, lo;
        hi = (m_act[p] > m_ramp);
        lo = (m_act[p] < -m_ramp);
        m_id[p][0] = hi; m_id[p][1] = !lo; m_id[p][2] = !hi; m_id[p][3] = lo;
      end
      if (in_valid && m_full == 0) begin
        m_stg[0] = int'(pa); m_stg[1] = int'(pb); m_stg[2] = int'(pc);
        m_sofs = int'(pz); m_full = 1;
      end else if (m_ramp == TOP && m_full == 1) begin
        for (int p = 0; p < 3; p++)
          m_act[p] = clampi(m_stg[p] + clampi(m_sofs, OMAX), TOP);
        m_full = 0;
      end
      if (m_up == 1) begin m_ramp++; if (m_ramp == TOP) m_up = 0; end
      else begin m_ramp--; if (m_ramp == 0) m_up = 1; end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2 ready", int'(in_ready), (m_full == 0) ? 1 : 0);
      chk("R9 gate_a", int'(gate_a), packg(0));
      chk("R9 gate_b", int'(gate_b), packg(1));
      chk("R9 gate_c", int'(gate_c), packg(2));
      chk("R8 level_a", int'(level_a), m_lv[0]);
      chk("R8 level_b", int'(level_b), m_lv[1]);
      chk("R8 level_c", int'(level_c), m_lv[2]);
    end
  end

  int pos_n[3], neg_n[3], zero_n[3], off13[3], off24[3];

  task automatic window();
    logic [3:0] gg;
    logic [1:0] ll;
    for (int p = 0; p < 3; p++) begin
      pos_n[p] = 0; neg_n[p] = 0; zero_n[p] = 0; off13[p] = 0; off24[p] = 0;
    end
    repeat (2 * TOP) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        gg = (p == 0) ? gate_a : (p == 1) ? gate_b : gate_c;
        ll = (p == 0) ? level_a : (p == 1) ? level_b : level_c;
        if (ll == 2'b01) pos_n[p]++;
        if (ll == 2'b11) neg_n[p]++;
        if (ll == 2'b00) zero_n[p]++;
        if (!gg[0] && !gg[2]) off13[p]++;
        if (!gg[1] && !gg[3]) off24[p]++;
      end
    end
  endtask

  task automatic send(int a, int b, int c, int z);
    @(negedge clk);
    pa = DW'(a); pb = DW'(b); pc = DW'(c); pz = DW'(z);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 ready low after accept", int'(in_ready), 0);
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int t0, t1;
    repeat (4) @(negedge clk);
    chk("R1 gate_a in reset", int'(gate_a), 0);
    chk("R1 level_b in reset", int'(level_b), 0);
    chk("R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gates after release", int'(gate_a | gate_b | gate_c), 0);
    running = 1'b1;

    send(50, -50, 0, 0);
    window();
    chk("R6 positive cycles phase a", pos_n[0], 99);
    chk("R7 negative cycles phase b", neg_n[1], 99);
    chk("R8 neutral cycles phase c", zero_n[2], 2 * TOP);
    chk("R9 no blanking at zero dead time", off13[0], 0);

    while (level_a == 2'b01) @(negedge clk);
    while (level_a != 2'b01) @(negedge clk);
    t0 = cyc;
    while (level_a == 2'b01) @(negedge clk);
    while (level_a != 2'b01) @(negedge clk);
    t1 = cyc;
    chk("R5 carrier period", t1 - t0, 2 * TOP);

    dead = DTW'(5);
    repeat (10) @(negedge clk);
    window();
    chk("R9 blanking cycles outer pair", off13[0], 10);
    chk("R9 inner pair stays complementary", off24[0], 0);
    chk("R6 level unaffected by dead time", pos_n[0], 99);

    send(0, 0, 0, 50);
    window();
    chk("R3 clamped positive offset phase a", pos_n[0], 9);
    chk("R3 clamped positive offset phase c", pos_n[2], 9);
    send(0, 0, 0, -50);
    window();
    chk("R3 clamped negative offset phase b", neg_n[1], 9);

    send(32767, 0, -32768, 5);
    window();
    chk("R4 saturate high phase a", pos_n[0], 2 * TOP - 1);
    chk("R3 offset reaches phase b", pos_n[1], 9);
    send(-32768, 0, 0, -5);
    window();
    chk("R4 saturate low phase a", neg_n[0], 2 * TOP - 1);
    chk("R4 no wrap phase a", pos_n[0], 0);

    running = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule